// File: doc/BRIEF.md
# Instruction-Dependent Test Data Output Edge Selector

This block drives the serial test data output of a boundary-scan test access port. The output bit and its enable come from two copies of the same register. One copy is clocked on the rising test-clock edge and the other on the falling edge. The instruction held in the instruction register picks which copy reaches the pin.

Standard boundary-scan instructions use the falling-edge copy, as the test standard requires. The debug instructions (debug reset assert, debug reset release and debug interrupt) use the rising-edge copy. Under a debug instruction each bit therefore appears half a test-clock period earlier.

The debug instruction codes are parameters. Any other code gets the standard falling-edge timing. The choice of copy is latched only when an instruction is committed, so it never changes while data is being shifted out.

Top module: `tdo_edge_sel`

## Requirements
- R1: While rst_ni is low, tdo_o and tdo_oe_o are 0. After reset, and before any commit, the block uses falling-edge timing.
- R2: In falling-edge mode, tdo_oe_o equals shift_i as sampled at the latest falling edge of tck_i. tdo_o equals data_i from that same edge, gated by that enable.
- R3: In rising-edge mode, tdo_oe_o and tdo_o take shift_i and data_i as sampled at the latest rising edge of tck_i. Each new bit therefore appears half a period before it would in falling-edge mode.
- R4: Committing any code in the parameter list DBG_CODES selects rising-edge mode. The default list is 4'h6, 4'h7 and 4'hB.
- R5: Committing any code outside DBG_CODES selects falling-edge mode. This includes 4'h0, 4'h1 and 4'hF, and it applies even when the previous mode was rising-edge.
- R6: The mode changes only at a rising tck_i edge where upd_ir_i is 1 and shift_i is 0. A change on ir_code_i alone has no effect on the output timing.
- R7: An upd_ir_i pulse while shift_i is 1 is ignored, and the current mode is kept.
- R8: Whenever tdo_oe_o is 0, tdo_o is 0, whatever the value of data_i.
- R9: The output enable moves on the same edge as the data. In rising-edge mode it asserts and deasserts half a period earlier than in falling-edge mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck_i | input | 1 | Test clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ir_code_i | input | IR_W | Instruction register contents |
| upd_ir_i | input | 1 | Instruction commit strobe, high in the update-IR state |
| shift_i | input | 1 | High while the port is in a shift state |
| data_i | input | 1 | Serial bit from the selected data register |
| tdo_o | output | 1 | Serial test data out, 0 when disabled |
| tdo_oe_o | output | 1 | Output enable for the pad tri-state driver |

## Verification
The assertions assume that shift_i stays low during reset. They also assume that shift_i is low for the whole test-clock period that starts at a commit. A real TAP state machine guarantees this, because several states lie between update-IR and any shift state. The stimulus changes all inputs 5 ns after a falling edge and returns shift_i low before every commit. Directed tasks compare the outputs 5 ns after each rising edge and each falling edge, and that pair of samples separates the two timings.

// File: rtl/tdo_sel_pkg.sv
package tdo_sel_pkg;
  typedef enum logic {
    EDGE_FALL = 1'b0,
    EDGE_RISE = 1'b1
  } edge_e;

  typedef struct packed {
    logic oe;
    logic bit_v;
  } tdo_pair_t;
endpackage

// File: rtl/tdo_mode_dec.sv
module tdo_mode_dec
  import tdo_sel_pkg::*;
#(
  parameter int unsigned              IR_W      = 4,
  parameter int unsigned              N_DBG     = 3,
  parameter logic [N_DBG*IR_W-1:0]    DBG_CODES = 12'hB76
) (
  input  logic            tck_i,
  input  logic            rst_ni,
  input  logic [IR_W-1:0] ir_code_i,
  input  logic            upd_ir_i,
  input  logic            shift_i,
  output edge_e           mode_o
);

  logic [N_DBG-1:0] hit;
  logic             commit;
  edge_e            mode_q;

  for (genvar g = 0; g < N_DBG; g++) begin : g_match
    assign hit[g] = (ir_code_i == DBG_CODES[g*IR_W +: IR_W]);
  end

  // commit only outside shift so the mux never moves under live data
  assign commit = upd_ir_i & ~shift_i;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)     mode_q <= EDGE_FALL;
    else if (commit) mode_q <= (|hit) ? EDGE_RISE : EDGE_FALL;
  end

  assign mode_o = mode_q;

  // R6
  mode_hold_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    !upd_ir_i |=> $stable(mode_q));

  // R7
  shift_upd_ignore_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (upd_ir_i && shift_i) |=> $stable(mode_q));

endmodule

// File: rtl/tdo_edge_flop.sv
module tdo_edge_flop
  import tdo_sel_pkg::*;
#(
  parameter bit RISE = 1'b0
) (
  input  logic      tck_i,
  input  logic      rst_ni,
  input  tdo_pair_t d_i,
  output tdo_pair_t q_o
);

  tdo_pair_t q;

  if (RISE) begin : g_rise
    always_ff @(posedge tck_i or negedge rst_ni) begin
      if (!rst_ni) q <= '0;
      else         q <= d_i;
    end
  end else begin : g_fall
    always_ff @(negedge tck_i or negedge rst_ni) begin
      if (!rst_ni) q <= '0;
      else         q <= d_i;
    end
  end

  assign q_o = q;

endmodule

// File: rtl/tdo_edge_sel.sv
module tdo_edge_sel
  import tdo_sel_pkg::*;
#(
  parameter int unsigned           IR_W      = 4,
  parameter int unsigned           N_DBG     = 3,
  parameter logic [N_DBG*IR_W-1:0] DBG_CODES = 12'hB76
) (
  input  logic            tck_i,
  input  logic            rst_ni,
  input  logic [IR_W-1:0] ir_code_i,
  input  logic            upd_ir_i,
  input  logic            shift_i,
  input  logic            data_i,
  output logic            tdo_o,
  output logic            tdo_oe_o
);

  edge_e     mode;
  tdo_pair_t d;
  tdo_pair_t r_q;
  tdo_pair_t f_q;
  tdo_pair_t sel;

  tdo_mode_dec #(
    .IR_W     (IR_W),
    .N_DBG    (N_DBG),
    .DBG_CODES(DBG_CODES)
  ) u_dec (
    .tck_i    (tck_i),
    .rst_ni   (rst_ni),
    .ir_code_i(ir_code_i),
    .upd_ir_i (upd_ir_i),
    .shift_i  (shift_i),
    .mode_o   (mode)
  );

  // both copies hold the same bit; only the capture edge differs
  assign d.oe    = shift_i;
  assign d.bit_v = data_i;

  tdo_edge_flop #(.RISE(1'b1)) u_rise (
    .tck_i (tck_i),
    .rst_ni(rst_ni),
    .d_i   (d),
    .q_o   (r_q)
  );

  tdo_edge_flop #(.RISE(1'b0)) u_fall (
    .tck_i (tck_i),
    .rst_ni(rst_ni),
    .d_i   (d),
    .q_o   (f_q)
  );

  assign sel      = (mode == EDGE_RISE) ? r_q : f_q;
  assign tdo_oe_o = sel.oe;
  assign tdo_o    = sel.oe & sel.bit_v;

  // R6
  sel_quiet_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    !$stable(mode) |-> (!r_q.oe && !f_q.oe && !tdo_oe_o));

  // R3
  rise_path_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (mode == EDGE_RISE) |-> (tdo_oe_o == $past(shift_i)) &&
                            (tdo_o == ($past(shift_i) & $past(data_i))));

  // R2
  fall_path_chk: assert property (@(negedge tck_i) disable iff (!rst_ni)
    (mode == EDGE_FALL) |-> (tdo_oe_o == $past(shift_i)) &&
                            (tdo_o == ($past(shift_i) & $past(data_i))));

endmodule

// File: tb/sim_tdo_edge_sel.sv
module sim_tdo_edge_sel;

  logic       tck = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] ir_code = 4'h0;
  logic       upd_ir = 1'b0;
  logic       shift = 1'b0;
  logic       data = 1'b0;
  logic       tdo;
  logic       tdo_oe;

  int n_chk = 0;
  int n_bad = 0;
  logic prev_oe = 1'b0;
  logic prev_bit = 1'b0;

  always #10 tck = ~tck;

  tdo_edge_sel u0 (
    .tck_i    (tck),
    .rst_ni   (rst_n),
    .ir_code_i(ir_code),
    .upd_ir_i (upd_ir),
    .shift_i  (shift),
    .data_i   (data),
    .tdo_o    (tdo),
    .tdo_oe_o (tdo_oe)
  );

  task automatic chk(string req, string what, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic to_drive();
    @(negedge tck); #5;
  endtask

  // enter at drive point, leave at drive point; shift stays low
  task automatic commit(logic [3:0] code);
    shift   = 1'b0;
    ir_code = code;
    upd_ir  = 1'b1;
    @(posedge tck); #5;
    upd_ir = 1'b0;
    to_drive();
    prev_oe  = 1'b0;
    prev_bit = 1'b0;
  endtask

  // one bit period: drive, check after rising, check after falling
  task automatic step(logic s, logic dv, logic rise, string req);
    shift = s;
    data  = dv;
    @(posedge tck); #5;
    chk(req, "oe@rise", tdo_oe, rise ? s : prev_oe);
    chk(req, "tdo@rise", tdo, rise ? (s & dv) : (prev_oe & prev_bit));
    to_drive();
    chk(req, "oe@fall", tdo_oe, s);
    chk(req, "tdo@fall", tdo, s & dv);
    if (!tdo_oe) chk("R8", "tdo quiet", tdo, 1'b0);
    prev_oe  = s;
    prev_bit = dv;
  endtask

  task automatic pattern(logic rise, string req);
    step(1'b1, 1'b1, rise, req);
    step(1'b1, 1'b0, rise, req);
    step(1'b1, 1'b1, rise, req);
    step(1'b1, 1'b1, rise, req);
    step(1'b0, 1'b1, rise, req);
    step(1'b0, 1'b0, rise, req);
  endtask

  task automatic t_reset();
    shift = 1'b1;
    data  = 1'b1;
    repeat (3) @(posedge tck);
    #5;
    chk("R1", "oe in reset", tdo_oe, 1'b0);
    chk("R1", "tdo in reset", tdo, 1'b0);
    shift = 1'b0;
    data  = 1'b0;
    to_drive();
    rst_n = 1'b1;
    to_drive();
    pattern(1'b0, "R1 R2 R9");
  endtask

  task automatic t_debug_codes();
    commit(4'h6); pattern(1'b1, "R4 R3 R9");
    commit(4'h7); pattern(1'b1, "R4 R3");
    commit(4'hB); pattern(1'b1, "R4 R3");
  endtask

  task automatic t_other_codes();
    commit(4'h0); pattern(1'b0, "R5 R2");
    commit(4'h6); pattern(1'b1, "R4");
    commit(4'hF); pattern(1'b0, "R5 R2");
    commit(4'h1); pattern(1'b0, "R5 R9");
  endtask

  task automatic t_no_update();
    commit(4'h7);
    ir_code = 4'h0;
    pattern(1'b1, "R6 rise kept");
    step(1'b1, 1'b1, 1'b1, "R6");
    ir_code = 4'hF;
    step(1'b1, 1'b0, 1'b1, "R6");
    step(1'b0, 1'b0, 1'b1, "R6");
    commit(4'h0);
    ir_code = 4'hB;
    pattern(1'b0, "R6 fall kept");
  endtask

  task automatic t_update_in_shift();
    commit(4'hB);
    shift   = 1'b1;
    data    = 1'b1;
    ir_code = 4'h0;
    upd_ir  = 1'b1;
    @(posedge tck); #5;
    upd_ir = 1'b0;
    chk("R7", "oe@rise", tdo_oe, 1'b1);
    chk("R7", "tdo@rise", tdo, 1'b1);
    to_drive();
    prev_oe  = 1'b1;
    prev_bit = 1'b1;
    step(1'b1, 1'b0, 1'b1, "R7");
    step(1'b0, 1'b0, 1'b1, "R7");
    pattern(1'b1, "R7");
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    #5;
    t_reset();
    t_debug_codes();
    t_other_codes();
    t_no_update();
    t_update_in_shift();
    finish_run();
  end

endmodule